// File: doc/BRIEF.md
# Programmable Peripheral Window Decoder

This decoder classifies each address on a 28-bit bus against two peripheral regions. The first is a fixed 4 KB page at the top of the active address space. The second is a relocatable 16 KB window, aligned to a 16 KB boundary, whose base is held in a 14-bit select register. The lower three 4 KB pages of the window are programmable peripheral space. The topmost page of the window is linked to the fixed page, so an access there reaches the same peripheral locations as an access to the fixed page.

A mode input chooses between a 256 MB map, where every address bit counts, and a 64 MB map, where the address and the window base are reduced to 26 bits before any comparison. In the 64 MB map the fixed page sits at 3FFF000h, and it repeats in every 64 MB alias above that. The outputs are the region hits, a peripheral-bus activate strobe, and a normalised location made of a 12-bit offset within the page and a 2-bit page index. The hit outputs are combinational in the address. Only the select register holds state.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset the select register is zero, so the window covers 0000000h–0003FFFh.
- R2: A write to the select register (win_we high at a rising edge) changes decoding only after that edge. Before the edge, the old base still applies.
- R3: In 256 MB mode (wide_map=1), addresses FFFF000h–FFFFFFFh raise hit_fixed with page_idx=3 and page_ofs=addr[11:0].
- R4: In 64 MB mode (wide_map=0), address bits 27:26 are ignored. Any address whose bits 25:12 are all ones raises hit_fixed with page_idx=3.
- R5: In 256 MB mode, 3FFF000h–3FFFFFFh is not a peripheral hit unless the window covers it.
- R6: An address whose bits above 13 equal the select register, with bits 13:12 in 0..2, raises hit_prog with page_idx=addr[13:12] and page_ofs=addr[11:0].
- R7: An address in the window's topmost page (bits 13:12 = 3) raises hit_fixed with page_idx=3. It also raises hit_mirror, unless that page is the fixed page itself.
- R8: bus_act is high exactly when hit_fixed or hit_prog is high. hit_fixed and hit_prog are never high together.
- R9: With no hit, all hit outputs, page_idx and page_ofs are zero.
- R10: In 64 MB mode the window comparison uses only bits 25:14 of the address and bits 11:0 of the select register. Select bits 13:12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_map | input | 1 | 1 = 256 MB map, 0 = 64 MB map |
| win_we | input | 1 | Select register write enable |
| win_wdata | input | 14 | New window base (address bits 27:14) |
| addr | input | 28 | Access address |
| hit_fixed | output | 1 | Fixed page or its mirror in the window |
| hit_prog | output | 1 | Programmable pages 0..2 of the window |
| hit_mirror | output | 1 | Window page linked to the fixed page |
| bus_act | output | 1 | Peripheral bus activate strobe |
| page_ofs | output | 12 | Offset within the hit page |
| page_idx | output | 2 | Page index within the peripheral space |

## Verification
The hardest case to reach is a window placed so that it overlaps the fixed page. In 64 MB mode this can also happen through a high select value that aliases down onto the fixed page. In that case the mirror must drop out while the fixed hit remains.

Random addresses almost never land there. The bench therefore programs select values such as 3FFFh, 0FFFh and 2FFFh in both modes. For each one it sweeps every window page, the fixed page and its aliases, and the page just below the fixed one. It then adds random addresses, and checks each result against an arithmetic range model.

// File: rtl/periph_window_decoder.sv
module periph_window_decoder #(
  parameter int AW       = 28,
  parameter int SEL_W    = 14,
  parameter int PG_W     = 12,
  parameter int NARROW_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_map,
  input  logic             win_we,
  input  logic [SEL_W-1:0] win_wdata,
  input  logic [AW-1:0]    addr,
  output logic             hit_fixed,
  output logic             hit_prog,
  output logic             hit_mirror,
  output logic             bus_act,
  output logic [PG_W-1:0]  page_ofs,
  output logic [AW-SEL_W-PG_W-1:0] page_idx
);
  localparam int WIN_LSB = AW - SEL_W;
  localparam int IDX_W   = WIN_LSB - PG_W;
  localparam int FIX_W   = AW - PG_W;
  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (win_we) sel_q <= win_wdata;

  logic [AW-1:0]    eff;
  logic [SEL_W-1:0] base_hi;
  logic [FIX_W-1:0] fix_top;
  logic [IDX_W-1:0] win_idx;
  logic             in_win, in_fix, top_pg;

  assign eff     = wide_map ? addr : (addr & NARROW_MASK);
  assign base_hi = wide_map ? sel_q : (sel_q & NARROW_MASK[AW-1:WIN_LSB]);
  assign fix_top = wide_map ? {FIX_W{1'b1}} : NARROW_MASK[AW-1:PG_W];
  assign win_idx = eff[WIN_LSB-1:PG_W];
  assign top_pg  = &win_idx;

  assign in_win  = eff[AW-1:WIN_LSB] == base_hi;
  assign in_fix  = eff[AW-1:PG_W] == fix_top;

  assign hit_prog   = in_win & ~top_pg;
  assign hit_fixed  = in_fix | (in_win & top_pg);
  assign hit_mirror = in_win & top_pg & ~in_fix;
  assign bus_act    = hit_prog | hit_fixed;

  assign page_idx = hit_prog ? win_idx : (hit_fixed ? {IDX_W{1'b1}} : '0);
  assign page_ofs = bus_act ? eff[PG_W-1:0] : '0;
endmodule

module periph_window_decoder_chk #(
  parameter int AW       = 28,
  parameter int SEL_W    = 14,
  parameter int PG_W     = 12,
  parameter int NARROW_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wide_map,
  input logic             win_we,
  input logic [SEL_W-1:0] win_wdata,
  input logic [AW-1:0]    addr,
  input logic             hit_fixed,
  input logic             hit_prog,
  input logic             hit_mirror,
  input logic             bus_act,
  input logic [PG_W-1:0]  page_ofs,
  input logic [AW-SEL_W-PG_W-1:0] page_idx
);
  localparam int WIN_LSB = AW - SEL_W;

  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act == (hit_fixed | hit_prog));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_fixed, hit_prog}));
  assert_prog_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_prog |-> (page_idx != '1));
  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mirror |-> (hit_fixed && page_idx == '1 && bus_act));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_act |-> (page_ofs == '0 && page_idx == '0 && !hit_mirror));
  assert_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_map && (&addr[NARROW_W-1:PG_W])) |-> (hit_fixed && page_idx == '1));
  assert_new_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_we) && wide_map && addr[AW-1:WIN_LSB] == $past(win_wdata)
      && addr[WIN_LSB-1:PG_W] != '1) |-> hit_prog);
endmodule

bind periph_window_decoder periph_window_decoder_chk #(
  .AW(AW), .SEL_W(SEL_W), .PG_W(PG_W), .NARROW_W(NARROW_W)
) u_chk (.*);

// File: tb/periph_window_decoder_tb.sv
module periph_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_map = 1'b1;
  logic        win_we = 1'b0;
  logic [13:0] win_wdata = '0;
  logic [27:0] addr = '0;
  logic        hit_fixed, hit_prog, hit_mirror, bus_act;
  logic [11:0] page_ofs;
  logic [1:0]  page_idx;

  int vectors = 0;
  int errors  = 0;
  logic [13:0] cur_sel = '0;

  always #5 clk = ~clk;

  periph_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wide_map(wide_map), .win_we(win_we),
    .win_wdata(win_wdata), .addr(addr), .hit_fixed(hit_fixed),
    .hit_prog(hit_prog), .hit_mirror(hit_mirror), .bus_act(bus_act),
    .page_ofs(page_ofs), .page_idx(page_idx)
  );

  task automatic check(input string tag);
    longint span, eff, base, flo;
    bit in_f, in_w;
    int pg;
    logic [17:0] exp_v, act_v;
    span = wide_map ? 64'd268435456 : 64'd67108864;
    eff  = longint'(addr) % span;
    base = (longint'(cur_sel) * 16384) % span;
    flo  = span - 4096;
    in_f = (eff >= flo) && (eff < flo + 4096);
    in_w = (eff >= base) && (eff < base + 16384);
    pg   = in_w ? int'((eff - base) / 4096) : 0;
    exp_v = '0;
    if (in_w && pg < 3) begin
      exp_v[17] = 1'b0; exp_v[16] = 1'b1; exp_v[15] = 1'b0; exp_v[14] = 1'b1;
      exp_v[13:12] = 2'(pg); exp_v[11:0] = 12'(eff % 4096);
    end else if (in_f || (in_w && pg == 3)) begin
      exp_v[17] = 1'b1; exp_v[16] = 1'b0; exp_v[15] = in_w && !in_f; exp_v[14] = 1'b1;
      exp_v[13:12] = 2'd3; exp_v[11:0] = 12'(eff % 4096);
    end
    act_v = {hit_fixed, hit_prog, hit_mirror, bus_act, page_idx, page_ofs};
    if (tag == "") begin
      if (in_w && pg < 3)      tag = wide_map ? "R6" : "R10";
      else if (in_w)           tag = "R7";
      else if (in_f)           tag = wide_map ? "R3" : "R4";
      else if (wide_map && addr[27:12] == 16'h3FFF) tag = "R5";
      else                     tag = "R9";
    end
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s/R8 mode=%0b sel=%h addr=%h actual=%h expected=%h",
               tag, wide_map, cur_sel, addr, act_v, exp_v);
    end
  endtask

  task automatic apply(input logic [27:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1 check(tag);
  endtask

  task automatic write_sel(input logic [13:0] v);
    @(negedge clk);
    win_we = 1'b1; win_wdata = v;
    @(negedge clk);
    win_we = 1'b0;
    cur_sel = v;
  endtask

  task automatic sweep(input logic [13:0] s);
    logic [27:0] b;
    write_sel(s);
    b = {s, 14'h0};
    for (int p = 0; p < 4; p++) begin
      apply(b + 28'(p * 4096), "");
      apply(b + 28'(p * 4096 + 12'h7A5), "");
      apply(b + 28'(p * 4096 + 12'hFFF), "");
    end
    apply(b - 28'd1, "");
    apply(b + 28'h4000, "");
    for (int k = 0; k < 4; k++) begin
      apply({2'(k), 26'h3FFF000}, "");
      apply({2'(k), 26'h3FFFFFF}, "");
      apply({2'(k), 26'h3FFEFFF}, "");
    end
    apply(28'hFFFF000, "");
    apply(28'hFFFFABC, "");
    for (int r = 0; r < 150; r++) apply(28'($urandom), "");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [13:0] sels [10];
    sels = '{14'h0000, 14'h3FFF, 14'h0FFF, 14'h2FFF, 14'h1234,
             14'h3FFE, 14'h0001, 14'h2ABC, 14'h1FFF, 14'h0FFE};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, window at zero
    apply(28'h0000000, "R1");
    apply(28'h0002345, "R1");
    apply(28'h0003010, "R1");
    rst_n = 1'b1;
    apply(28'h0001FFF, "R1");
    apply(28'h0004000, "R1");

    // R2: the write only takes effect after the edge
    @(negedge clk);
    wide_map = 1'b1;
    win_we = 1'b1; win_wdata = 14'h0ABC; addr = 28'h2AF0123;
    #1 check("R2");
    @(posedge clk);
    cur_sel = 14'h0ABC;
    #1 check("R2");
    @(negedge clk);
    win_we = 1'b0;
    apply(28'h2AF1456, "R2");

    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      wide_map = m[0];
      foreach (sels[i]) sweep(sels[i]);
      for (int r = 0; r < 8; r++) sweep(14'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule